// File: doc/BRIEF.md
# Sample-and-Hold Stream Decoupler

This block joins a producer stream to a consumer stream, each of which uses a strobe from the sender and an acknowledge from the receiver. The two sides may run at unrelated rates. The block keeps one held word. Every word the producer offers overwrites that word. Whenever the consumer signals that it is ready, the held word is presented to it. Neither side ever waits for the other. When the producer is faster, surplus words are lost. When the consumer is faster, the same word is sent again. No queueing takes place.

The input acknowledge stays high at all times outside reset, so the producer is never throttled. A word offered in a given cycle is forwarded straight to the output in that same cycle, because the input is serviced ahead of the output. Parameters select a registered output path in place of the forwarding path, and select whether the reset value of zero may be emitted before the first capture. The defaults are forwarding and zero emission. An exception output exists for uniformity with sibling stream blocks and is always low.

Top module: `sh_decoupler`

## Requirements
- R1: A word moves across a port on a rising clock edge only when the strobe and the acknowledge of that port are both high.
- R2: From the first clock edge after reset is released, `in_ack` stays at 1 continuously, so any word offered is taken at the next edge.
- R3: While `in_stb` is 0, `in_data` is ignored and the held word keeps its value.
- R4: `out_data` always carries the most recent captured word, and earlier uncollected words are overwritten and dropped.
- R5: If no word has been captured since the last output transfer, the next output transfer repeats the same held word.
- R6: A word taken from the input in a cycle appears on `out_data` during that same cycle, before the edge that captures it.
- R7: After the first clock edge past reset, `out_stb` equals `out_ack`. Before any capture, the word presented is zero.
- R8: A synchronous active-high `rst` clears the held word to zero and forces `in_ack` and `out_stb` to 0. A word offered at a reset edge is not kept.
- R9: `exception` is always 0.
- R10: A low `out_ack` never stops input capture. Words keep being taken while the consumer is not ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 32 | Word offered by the producer |
| in_stb | input | 1 | Producer has a word available |
| in_ack | output | 1 | Block will take the offered word |
| out_data | output | 32 | Held (or forwarded) word for the consumer |
| out_stb | output | 1 | Word is presented to the consumer |
| out_ack | input | 1 | Consumer is ready for a word |
| exception | output | 1 | Error flag, constant 0 |

## Verification
With the default forwarding path, `out_data` and `out_stb` are combinational in the current inputs and in registers that update at the edge. The results of a stimulus are therefore due in the same cycle it is driven, and a captured word is still present in every later cycle. The bench drives inputs just after a falling edge and samples halfway to the next rising edge. It then advances one edge, so each check sees exactly one more capture than the previous one. Effects of reset are due one edge after `rst` is sampled high. Release effects, namely `in_ack` rising and `out_stb` following `out_ack`, are due one edge after `rst` is sampled low, and checks are placed in those cycles.

// File: rtl/sh_pkg.sv
package sh_pkg;

   localparam int SH_WORD_W_DEF = 32;

   typedef enum logic {
      SH_PATH_REG = 1'b0,
      SH_PATH_FWD = 1'b1
   } sh_path_e;

   function automatic logic sh_xfer(input logic stb, input logic ack);
      return stb & ack;
   endfunction

endpackage

// File: rtl/sh_capture.sv
module sh_capture #(
   parameter int WORD_W = sh_pkg::SH_WORD_W_DEF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              src_stb,
   input  logic [WORD_W-1:0] src_word,
   output logic              src_ack,
   output logic              take,
   output logic [WORD_W-1:0] hold_word
);

   initial begin
      if (WORD_W < 1) $error("sh_capture: WORD_W must be positive");
   end

   assign take = sh_pkg::sh_xfer(src_stb, src_ack);

   always_ff @(posedge clk) begin
      if (rst) begin
         src_ack <= 1'b0;
      end else begin
         src_ack <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_word <= '0;
      end else if (take) begin
         hold_word <= src_word;
      end
   end

endmodule

// File: rtl/sh_present.sv
module sh_present #(
   parameter int WORD_W     = sh_pkg::SH_WORD_W_DEF,
   parameter bit FORWARD    = 1'b1,
   parameter bit PRIME_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take,
   input  logic [WORD_W-1:0] src_word,
   input  logic [WORD_W-1:0] hold_word,
   input  logic              dst_ack,
   output logic              dst_stb,
   output logic [WORD_W-1:0] dst_word
);

   localparam sh_pkg::sh_path_e PATH = FORWARD ? sh_pkg::SH_PATH_FWD
                                               : sh_pkg::SH_PATH_REG;

   logic have_word;
   logic avail;

   generate
      if (PRIME_ZERO) begin : g_prime
         always_ff @(posedge clk) begin
            if (rst) have_word <= 1'b0;
            else     have_word <= 1'b1;
         end
      end else begin : g_wait
         always_ff @(posedge clk) begin
            if (rst)       have_word <= 1'b0;
            else if (take) have_word <= 1'b1;
         end
      end
   endgenerate

   generate
      if (PATH == sh_pkg::SH_PATH_FWD) begin : g_fwd
         assign dst_word = take ? src_word : hold_word;
         assign avail    = have_word | take;
      end else begin : g_reg
         assign dst_word = hold_word;
         assign avail    = have_word;
      end
   endgenerate

   assign dst_stb = avail & dst_ack;

endmodule

// File: rtl/sh_decoupler.sv
module sh_decoupler #(
   parameter int DATA_W     = 32,
   parameter bit FORWARD    = 1'b1,
   parameter bit PRIME_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_stb,
   output logic              in_ack,
   output logic [DATA_W-1:0] out_data,
   output logic              out_stb,
   input  logic              out_ack,
   output logic              exception
);

   initial begin
      if (DATA_W < 1 || DATA_W > 1024) $error("sh_decoupler: DATA_W out of range");
   end

   logic              take_w;
   logic [DATA_W-1:0] hold_w;

   sh_capture #(.WORD_W(DATA_W)) u_cap (
      .clk       (clk),
      .rst       (rst),
      .src_stb   (in_stb),
      .src_word  (in_data),
      .src_ack   (in_ack),
      .take      (take_w),
      .hold_word (hold_w)
   );

   sh_present #(
      .WORD_W     (DATA_W),
      .FORWARD    (FORWARD),
      .PRIME_ZERO (PRIME_ZERO)
   ) u_pres (
      .clk       (clk),
      .rst       (rst),
      .take      (take_w),
      .src_word  (in_data),
      .hold_word (hold_w),
      .dst_ack   (out_ack),
      .dst_stb   (out_stb),
      .dst_word  (out_data)
   );

   assign exception = 1'b0;

endmodule

// File: rtl/sh_decoupler_chk.sv
module sh_decoupler_chk #(
   parameter int DATA_W     = 32,
   parameter bit FORWARD    = 1'b1,
   parameter bit PRIME_ZERO = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] in_data,
   input logic              in_stb,
   input logic              in_ack,
   input logic [DATA_W-1:0] out_data,
   input logic              out_stb,
   input logic              out_ack,
   input logic              exception
);

   logic armed;
   logic live;
   logic take;

   assign take = in_stb & in_ack;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed <= 1'b1;
         live  <= 1'b0;
      end else begin
         live  <= armed;
      end
   end

   p_ack_always_r2: assert property (@(posedge clk) disable iff (rst)
      live |-> in_ack);

   p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
      (live && $past(live) && !take && !$past(take)) |-> $stable(out_data));

   p_latest_kept_r4: assert property (@(posedge clk) disable iff (rst)
      (live && $past(take) && !take) |-> (out_data == $past(in_data)));

   p_stb_follows_ack_r7: assert property (@(posedge clk) disable iff (rst)
      (live && PRIME_ZERO) |-> (out_stb == out_ack));

   p_no_ack_in_reset_r8: assert property (@(posedge clk)
      (armed && $past(rst)) |-> (!in_ack && !out_stb));

   p_exception_low_r9: assert property (@(posedge clk) disable iff (rst)
      live |-> !exception);

   generate
      if (FORWARD) begin : g_fwd_chk
         p_same_round_r6: assert property (@(posedge clk) disable iff (rst)
            take |-> (out_data == in_data));
      end
   endgenerate

endmodule

bind sh_decoupler sh_decoupler_chk #(
   .DATA_W     (DATA_W),
   .FORWARD    (FORWARD),
   .PRIME_ZERO (PRIME_ZERO)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_data   (in_data),
   .in_stb    (in_stb),
   .in_ack    (in_ack),
   .out_data  (out_data),
   .out_stb   (out_stb),
   .out_ack   (out_ack),
   .exception (exception)
);

// File: tb/sh_decoupler_tb.sv
module sh_decoupler_tb;

   localparam int W = 32;

   typedef struct packed {
      logic         stb;
      logic [W-1:0] din;
      logic         ack;
      logic [W-1:0] exp_data;
   } vec_t;

   // Each row: offer (stb,din), consumer ready (ack), expected out_data in that same cycle.
   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'hDEAD_0000, 1'b1, 32'h0000_0000},  // R7 zero before first capture, R3
      '{1'b1, 32'hA1A1_0001, 1'b1, 32'hA1A1_0001},  // R6 same-cycle forward
      '{1'b0, 32'h0000_FFFF, 1'b1, 32'hA1A1_0001},  // R5 repeat
      '{1'b1, 32'hB2B2_0002, 1'b0, 32'hB2B2_0002},  // R10 capture with consumer idle
      '{1'b1, 32'hC3C3_0003, 1'b0, 32'hC3C3_0003},  // R4 overwrite
      '{1'b0, 32'h1111_1111, 1'b1, 32'hC3C3_0003},  // R4 B dropped, C kept
      '{1'b0, 32'h2222_2222, 1'b0, 32'hC3C3_0003},  // R3 hold
      '{1'b1, 32'hD4D4_0004, 1'b1, 32'hD4D4_0004},  // R1 transfer
      '{1'b0, 32'hE5E5_0005, 1'b1, 32'hD4D4_0004}   // R3 data ignored without strobe
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] in_data = '0;
   logic         in_stb = 1'b0;
   logic         in_ack;
   logic [W-1:0] out_data;
   logic         out_stb;
   logic         out_ack = 1'b0;
   logic         exception;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   sh_decoupler #(.DATA_W(W)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_data   (in_data),
      .in_stb    (in_stb),
      .in_ack    (in_ack),
      .out_data  (out_data),
      .out_stb   (out_stb),
      .out_ack   (out_ack),
      .exception (exception)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic stb, input logic [W-1:0] d, input logic ack);
      @(negedge clk);
      in_stb  = stb;
      in_data = d;
      out_ack = ack;
      #5;
   endtask

   initial begin
      // reset state
      repeat (3) @(posedge clk);
      drive(1'b1, 32'h9999_9999, 1'b1);
      check("R8 in_ack in reset", {31'b0, in_ack}, 32'd0);
      check("R8 out_stb in reset", {31'b0, out_stb}, 32'd0);
      check("R8 out_data in reset", out_data, 32'd0);
      @(negedge clk);
      rst = 1'b0;
      in_stb = 1'b0;
      @(posedge clk);

      // table walk
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].stb, VEC[i].din, VEC[i].ack);
         check("R4 R5 R6 out_data", out_data, VEC[i].exp_data);
         check("R7 out_stb", {31'b0, out_stb}, {31'b0, VEC[i].ack});
         check("R2 R10 in_ack", {31'b0, in_ack}, 32'd1);
         check("R9 exception", {31'b0, exception}, 32'd0);
         @(posedge clk);
      end

      // directed: reset mid-run with a word offered at the reset edge
      @(negedge clk);
      rst     = 1'b1;
      in_stb  = 1'b1;
      in_data = 32'hF6F6_0006;
      out_ack = 1'b1;
      @(posedge clk);
      #5;
      check("R8 held cleared", out_data, 32'd0);
      check("R8 in_ack cleared", {31'b0, in_ack}, 32'd0);
      check("R8 out_stb cleared", {31'b0, out_stb}, 32'd0);
      @(negedge clk);
      rst    = 1'b0;
      in_stb = 1'b0;
      @(posedge clk);
      drive(1'b0, 32'h7777_7777, 1'b1);
      check("R7 zero after reset", out_data, 32'd0);
      check("R7 out_stb after release", {31'b0, out_stb}, 32'd1);
      check("R2 in_ack after release", {31'b0, in_ack}, 32'd1);
      @(posedge clk);

      // directed: burst of captures with consumer idle, then collect latest
      for (int k = 0; k < 4; k++) begin
         drive(1'b1, 32'h5000_0000 + k, 1'b0);
         check("R10 in_ack during burst", {31'b0, in_ack}, 32'd1);
         @(posedge clk);
      end
      drive(1'b0, 32'h0, 1'b1);
      check("R4 latest of burst", out_data, 32'h5000_0003);
      @(posedge clk);
      drive(1'b0, 32'h0, 1'b1);
      check("R5 latest repeated", out_data, 32'h5000_0003);
      check("R1 R7 out_stb with ack", {31'b0, out_stb}, 32'd1);
      @(posedge clk);
      drive(1'b0, 32'h0, 1'b0);
      check("R1 R7 out_stb without ack", {31'b0, out_stb}, 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule